// File: doc/BRIEF.md
# Error Flag Promotion Unit

This block sits inline in a 10-bit serial-digital video word stream. It looks for error-detection ancillary packets. When the receive-mode input is high at the moment such a packet is found, it rewrites the three per-region flag words in the packet: the ancillary flags, the active-picture flags and the full-field flags. In each region, a locally raised "error detected here" flag is turned into an "error detected upstream" flag, and the same is done for the "internal error here" flag. The packet checksum is rebuilt so the packet stays well formed for the next stage.

Each word is presented with a valid strobe. Every word, inside a packet or not, leaves the block exactly one cycle after it enters. A downstream stage therefore sees the same word timing it would see without the block. When the receive-mode input is low, the stream is copied through unchanged. The block does not generate packets and does not check CRCs.

Top module: `edh_flag_promoter`

## Requirements
- R1: A packet whose identifier word arrives while `rxMode` is low is emitted with every word identical to its input, the checksum word included.
- R2: In an edited flag word, bit 2 (locally detected error) is emitted as 0. Bit 3 (upstream detected error) is emitted as the OR of input bits 2 and 3.
- R3: In an edited flag word, bit 4 (internal error here) is emitted as 0. Bit 5 (internal error upstream) is emitted as the OR of input bits 4 and 5.
- R4: Only user data words 6, 7 and 8 (ancillary, active picture and full field, counted from 0) are edited, each on its own input value. Bit 6 (unknown-status flag), bits 0, 1 and 7, and all other user data words, header words and non-packet words pass unchanged.
- R5: Every edited flag word carries even parity over bits 8:0 in bit 8, and bit 9 equals the inverse of bit 8.
- R6: In an edited packet, the checksum word is replaced. Bits 8:0 become the 9-bit sum of bits 8:0 of the identifier, block number, data count and the 16 user data words as emitted, and bit 9 is the inverse of bit 8.
- R7: A packet is recognised only by the valid words 0x000, 0x3FF, 0x3FF followed by the identifier 0x1F4. The data count word (bits 7:0) must equal 16, otherwise the rest of the packet passes unchanged.
- R8: `rxMode` is sampled on the identifier word and that value governs the whole packet. A change of `rxMode` later in the packet has no effect on that packet.
- R9: `outValid` equals `inValid` delayed by one cycle, and `outWord` then carries the processed form of that word. Cycles with `inValid` low are skipped by the packet parser, so gaps inside a packet do not disturb it.
- R10: While reset is high, `outValid` and `outWord` are 0 at the following clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rxMode | input | 1 | Enables flag promotion for packets that start while it is high |
| inWord | input | 10 | Incoming video word |
| inValid | input | 1 | Qualifies `inWord` |
| outWord | output | 10 | Outgoing video word, one cycle after input |
| outValid | output | 1 | Qualifies `outWord` |

## Verification
The first sweep runs 32 packets with promotion on. The ancillary flag word steps through all 32 five-bit patterns, and the other two regions get different scrambled patterns, so each OR-and-clear rule can be told apart per bit and per region. Catching a swapped region or a wrong field position depends on these differing patterns. The same sweep is repeated with promotion off, which separates real edits from plain pass-through, and the checksum is predicted from the emitted words in both cases. Further packets toggle the mode after the identifier, carry a wrong data count, contain an idle gap, or follow a broken flag sequence. These show that the mode is latched per packet, that format rejection works, that the parser skips invalid cycles, and that detection requires the exact sequence.

// File: rtl/edh_promo_pkg.sv
package edh_promo_pkg;

  // Identifier word of the error-detection packet
  localparam logic [9:0] EDH_DID = 10'h1F4;

  // Strobes from the control to the datapath, one word at a time
  typedef struct packed {
    logic accLoad;   // identifier word: start checksum
    logic accAdd;    // header or user word: add emitted word
    logic flagEdit;  // rewrite this word as a flag word
    logic csumSwap;  // replace this word by the rebuilt checksum
  } promoCtl_t;

endpackage

// File: rtl/edh_promo_ctrl.sv
module edh_promo_ctrl
  import edh_promo_pkg::*;
#(
  parameter int WORD_W     = 10,
  parameter int UDW_COUNT  = 16,
  parameter int FLAG_FIRST = 6,
  parameter int FLAG_WORDS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxMode,
  input  logic [WORD_W-1:0] inWord,
  input  logic              inValid,
  output promoCtl_t         ctl
);

  localparam int IDX_W = $clog2(UDW_COUNT);
  localparam logic [IDX_W:0] FLAG_LO = (IDX_W+1)'(FLAG_FIRST);
  localparam logic [IDX_W:0] FLAG_HI = (IDX_W+1)'(FLAG_FIRST + FLAG_WORDS);
  localparam logic [IDX_W-1:0] UDW_LAST = IDX_W'(UDW_COUNT - 1);

  typedef enum logic [2:0] {ST_SEEK, ST_DBN, ST_DCNT, ST_UDW, ST_CSUM} pktState_t;

  pktState_t        state;
  logic [1:0]       adfCnt;
  logic             editOn;
  logic [IDX_W-1:0] udwIdx;

  logic isZero, isOnes, isDid, dcGood, inFlagRange;

  assign isZero      = (inWord == '0);
  assign isOnes      = (&inWord);
  assign isDid       = (inWord == EDH_DID);
  assign dcGood      = (inWord[7:0] == 8'(UDW_COUNT));
  assign inFlagRange = ({1'b0, udwIdx} >= FLAG_LO) && ({1'b0, udwIdx} < FLAG_HI);

  always_comb begin
    ctl = '0;
    if (inValid) begin
      case (state)
        ST_SEEK: ctl.accLoad  = (adfCnt == 2'd3) && isDid;
        ST_DBN,
        ST_DCNT: ctl.accAdd   = 1'b1;
        ST_UDW: begin
          ctl.accAdd   = 1'b1;
          ctl.flagEdit = editOn && inFlagRange;
        end
        ST_CSUM: ctl.csumSwap = editOn;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_SEEK;
      adfCnt <= '0;
      editOn <= 1'b0;
      udwIdx <= '0;
    end else if (inValid) begin
      case (state)
        ST_SEEK: begin
          if (adfCnt == 2'd3 && isDid) begin
            state  <= ST_DBN;
            editOn <= rxMode;
            adfCnt <= '0;
          end else if (isZero) begin
            adfCnt <= 2'd1;
          end else if (isOnes && (adfCnt == 2'd1 || adfCnt == 2'd2)) begin
            adfCnt <= adfCnt + 2'd1;
          end else begin
            adfCnt <= '0;
          end
        end
        ST_DBN: state <= ST_DCNT;
        ST_DCNT: begin
          udwIdx <= '0;
          state  <= dcGood ? ST_UDW : ST_SEEK;
        end
        ST_UDW: begin
          udwIdx <= udwIdx + 1'b1;
          if (udwIdx == UDW_LAST) state <= ST_CSUM;
        end
        ST_CSUM: state <= ST_SEEK;
        default: state <= ST_SEEK;
      endcase
    end
  end

endmodule

// File: rtl/edh_promo_dp.sv
module edh_promo_dp
  import edh_promo_pkg::*;
#(
  parameter int WORD_W   = 10,
  parameter int FLAG_LSB = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  promoCtl_t         ctl,
  input  logic [WORD_W-1:0] inWord,
  input  logic              inValid,
  output logic [WORD_W-1:0] outWord,
  output logic              outValid
);

  localparam int PAR_BIT = WORD_W - 2;   // parity bit position
  localparam int FLAG_N  = 5;
  localparam int PAIRS   = 2;            // (here, upstream) pairs

  logic [FLAG_N-1:0]  inFlags, newFlags;
  logic [PAR_BIT-1:0] body;
  logic               par;
  logic [WORD_W-1:0]  editWord, csumWord, nextWord;
  logic [PAR_BIT:0]   acc;

  assign inFlags = inWord[FLAG_LSB +: FLAG_N];

  // Each pair folds its "here" flag into its "upstream" flag
  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    assign newFlags[2*k]   = 1'b0;
    assign newFlags[2*k+1] = inFlags[2*k] | inFlags[2*k+1];
  end
  assign newFlags[FLAG_N-1] = inFlags[FLAG_N-1];

  always_comb begin
    body = inWord[PAR_BIT-1:0];
    body[FLAG_LSB +: FLAG_N] = newFlags;
  end

  assign par      = ^body;
  assign editWord = {~par, par, body};
  assign csumWord = {~acc[PAR_BIT], acc};

  always_comb begin
    if (ctl.flagEdit)      nextWord = editWord;
    else if (ctl.csumSwap) nextWord = csumWord;
    else                   nextWord = inWord;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      outWord  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) outWord <= nextWord;
      if (ctl.accLoad)     acc <= inWord[PAR_BIT:0];
      else if (ctl.accAdd) acc <= acc + nextWord[PAR_BIT:0];
    end
  end

endmodule

// File: rtl/edh_flag_promoter.sv
module edh_flag_promoter
  import edh_promo_pkg::*;
#(
  parameter int WORD_W     = 10,
  parameter int UDW_COUNT  = 16,
  parameter int FLAG_FIRST = 6,
  parameter int FLAG_WORDS = 3,
  parameter int FLAG_LSB   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxMode,
  input  logic [WORD_W-1:0] inWord,
  input  logic              inValid,
  output logic [WORD_W-1:0] outWord,
  output logic              outValid
);

  promoCtl_t ctl;

  edh_promo_ctrl #(
    .WORD_W(WORD_W), .UDW_COUNT(UDW_COUNT),
    .FLAG_FIRST(FLAG_FIRST), .FLAG_WORDS(FLAG_WORDS)
  ) i_ctrl (
    .clk(clk), .rst(rst), .rxMode(rxMode),
    .inWord(inWord), .inValid(inValid), .ctl(ctl)
  );

  edh_promo_dp #(.WORD_W(WORD_W), .FLAG_LSB(FLAG_LSB)) i_dp (
    .clk(clk), .rst(rst), .ctl(ctl),
    .inWord(inWord), .inValid(inValid),
    .outWord(outWord), .outValid(outValid)
  );

endmodule

// File: rtl/edh_flag_promoter_chk.sv
module edh_flag_promoter_chk (
  input logic       clk,
  input logic       rst,
  input logic [9:0] inWord,
  input logic       inValid,
  input logic [9:0] outWord,
  input logic       outValid,
  input logic       flagEdit,
  input logic       csumSwap
);

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  // R9
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  // R1
  edit_only_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && outWord != $past(inWord)) |-> $past(flagEdit || csumSwap));

  // R2
  here_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flagEdit |=> (!outWord[2] && !outWord[4]));

  // R5
  flag_parity_chk: assert property (@(posedge clk) disable iff (rst)
    flagEdit |=> ((^outWord[8:0]) == 1'b0 && outWord[9] != outWord[8]));

  // R6
  csum_form_chk: assert property (@(posedge clk) disable iff (rst)
    csumSwap |=> (outWord[9] != outWord[8]));

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flagEdit, csumSwap}));

  // R10
  reset_out_chk: assert property (@(posedge clk)
    rst |=> (!outValid && outWord == 10'd0));

endmodule

bind edh_flag_promoter edh_flag_promoter_chk i_chk (
  .clk(clk), .rst(rst), .inWord(inWord), .inValid(inValid),
  .outWord(outWord), .outValid(outValid),
  .flagEdit(ctl.flagEdit), .csumSwap(ctl.csumSwap)
);

// File: tb/test_edh_flag_promoter.sv
module test_edh_flag_promoter;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxMode = 1'b0;
  logic [9:0] inWord = '0;
  logic       inValid = 1'b0;
  logic [9:0] outWord;
  logic       outValid;

  int checks = 0;
  int errors = 0;

  edh_flag_promoter i_edh_flag_promoter (
    .clk(clk), .rst(rst), .rxMode(rxMode),
    .inWord(inWord), .inValid(inValid),
    .outWord(outWord), .outValid(outValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [9:0] mk(input logic [7:0] b);
    return {~(^b), ^b, b};
  endfunction

  function automatic logic [4:0] prom(input logic [4:0] f);
    return {f[4], f[3] | f[2], 1'b0, f[1] | f[0], 1'b0};
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%03h expected=%03h", tag, act, exp);
    end
  endtask

  task automatic sendWord(input logic [9:0] w, input logic [9:0] e, input string tag);
    inWord = w;
    inValid = 1'b1;
    @(negedge clk);
    check(outValid && outWord == e, tag, outWord, e);
  endtask

  task automatic gapCycle();
    inValid = 1'b0;
    inWord = 10'h155;
    @(negedge clk);
    check(!outValid, "R9 gap", {9'd0, outValid}, 10'd0);
  endtask

  task automatic sendPkt(input logic [4:0] fAnc, input logic [4:0] fAp,
                         input logic [4:0] fFf, input bit mode,
                         input logic [7:0] dc, input bit flip, input bit withGap);
    logic [9:0] udwIn [16];
    logic [9:0] udwEx [16];
    logic [8:0] sumIn, sumEx;
    logic [9:0] dbnW, dcW, csIn, csEx;
    logic [4:0] f;
    bit editOn;
    string tag;
    editOn = mode && (dc == 8'd16);
    dbnW = mk(8'h00);
    dcW  = mk(dc);
    for (int i = 0; i < 16; i++) begin
      if (i >= 6 && i <= 8) begin
        f = (i == 6) ? fAnc : (i == 7) ? fAp : fFf;
        udwIn[i] = mk({1'b0, f, 2'b00});
        udwEx[i] = mk({1'b0, prom(f), 2'b00});
      end else begin
        udwIn[i] = mk(8'(i * 37 + 3));
        udwEx[i] = udwIn[i];
      end
    end
    sumIn = 9'h1F4 + dbnW[8:0] + dcW[8:0];
    sumEx = sumIn;
    for (int i = 0; i < 16; i++) begin
      sumIn = sumIn + udwIn[i][8:0];
      sumEx = sumEx + udwEx[i][8:0];
    end
    csIn = {~sumIn[8], sumIn};
    csEx = {~sumEx[8], sumEx};
    tag = !mode ? "R1" : (dc != 8'd16) ? "R7 dc" : flip ? "R8" : "R4";
    rxMode = mode;
    sendWord(10'h000, 10'h000, "R7");
    sendWord(10'h3FF, 10'h3FF, "R7");
    sendWord(10'h3FF, 10'h3FF, "R7");
    sendWord(10'h1F4, 10'h1F4, "R7");
    if (flip) rxMode = ~mode;
    sendWord(dbnW, dbnW, "R4 hdr");
    sendWord(dcW, dcW, "R4 hdr");
    for (int i = 0; i < 16; i++) begin
      if (withGap && i == 4) gapCycle();
      if (i >= 6 && i <= 8 && editOn)
        sendWord(udwIn[i], udwEx[i], flip ? "R8 R2 R3 R5" : "R2 R3 R4 R5");
      else
        sendWord(udwIn[i], editOn ? udwEx[i] : udwIn[i], withGap ? "R9" : tag);
    end
    sendWord(csIn, editOn ? csEx : csIn, editOn ? "R6" : tag);
    sendWord(mk(8'h40), mk(8'h40), "R4 idle");
    rxMode = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!outValid && outWord == 10'd0, "R10 reset", outWord, 10'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!outValid, "R9 idle", {9'd0, outValid}, 10'd0);

    // Flag sweep, promotion on then off
    for (int v = 0; v < 32; v++)
      sendPkt(5'(v), 5'((v * 7) % 32), 5'((v * 13 + 5) % 32), 1'b1, 8'd16, 1'b0, 1'b0);
    for (int v = 0; v < 32; v++)
      sendPkt(5'(v), 5'((v * 11 + 3) % 32), 5'((v * 5 + 9) % 32), 1'b0, 8'd16, 1'b0, 1'b0);

    // Mode changed after the identifier (R8)
    sendPkt(5'h1F, 5'h05, 5'h0A, 1'b1, 8'd16, 1'b1, 1'b0);
    sendPkt(5'h1F, 5'h05, 5'h0A, 1'b0, 8'd16, 1'b1, 1'b0);

    // Wrong data count (R7)
    sendPkt(5'h15, 5'h0F, 5'h11, 1'b1, 8'd15, 1'b0, 1'b0);

    // Gap inside a packet (R9)
    sendPkt(5'h0B, 5'h14, 5'h1D, 1'b1, 8'd16, 1'b0, 1'b1);

    // Broken flag sequence: no packet may be detected (R7)
    rxMode = 1'b1;
    sendWord(10'h000, 10'h000, "R7");
    sendWord(10'h3FF, 10'h3FF, "R7");
    sendWord(10'h1F4, 10'h1F4, "R7");
    for (int i = 0; i < 20; i++)
      sendWord(mk({1'b0, 5'(i), 2'b00}), mk({1'b0, 5'(i), 2'b00}), "R7 nopkt");
    rxMode = 1'b0;

    // Restarted sequence 000 3FF 000 3FF 3FF still detected
    sendWord(10'h000, 10'h000, "R7");
    sendWord(10'h3FF, 10'h3FF, "R7");
    sendPkt(5'h03, 5'h0C, 5'h1F, 1'b1, 8'd16, 1'b0, 1'b0);

    gapCycle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule